// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and turns qualifying activity on each of them into an interrupt request. Every pin has its own two-bit sense field that selects one of four triggers: a low level, any edge, a falling edge or a rising edge. Pins are read from their pad value whatever their direction, so a pin the chip itself drives can still raise a request, which gives software a way to create its own interrupts.

Software programs the block through a simple byte-wide write port with four addresses: two sense bytes (one for pins 0 to 3, one for pins 4 to 7), an enable mask, and a write-one-to-clear flag register. Edge triggers set a sticky flag per pin after the pin passes through a two-flop synchronizer; a level trigger requests for as long as the pin stays low and sets no flag. The per-pin requests are combined with a global interrupt enable into a single request to the processor. A separate combinational wake output, which needs no running clock, reports level activity on any pin and edge activity on pins 0 to 3 only.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset all sense fields, the enable mask and all flags are zero; with every pin held high, flags_o, req_o, irq_o and wake_o are all low.
- R2: Write address 0 holds the sense byte for pins 0 to 3 and address 1 the sense byte for pins 4 to 7; within a byte, bits [2k+1:2k] are the field of the k-th pin of that group. Address 2 is the enable mask (bit n for pin n) and address 3 is the flag clear register.
- R3: Sense value 00 selects low level: req_o bit n is high while pin n is enabled and its synchronized value is low, and no flag bit is set by that pin.
- R4: Sense values 01 (any edge), 10 (falling) and 11 (rising) set flags_o bit n on a matching change of pin n; the flag is visible after the third rising clock edge following the pin change (two synchronizer flops plus the flag register), and a non-matching change sets nothing.
- R5: A flag is set whether or not the pin is enabled; req_o bit n is the enable bit n AND (flag n OR active low level on pin n).
- R6: Writing address 3 clears every flag whose data bit is 1 and leaves flags with a 0 data bit untouched; if a clear and a new edge for the same pin fall in the same cycle the flag stays set.
- R7: irq_o is high exactly when the global enable input is high and at least one req_o bit is high.
- R8: wake_o is combinational from the pad values: an enabled pin in level mode that is low raises it at once on any of the eight pins; an enabled pin 0 to 3 in an edge mode raises it when the pad differs from the last synchronized value in the selected direction; pins 4 to 7 in edge modes never raise it; the global enable does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Pad values of the external interrupt pins |
| gie_i | input | 1 | Global interrupt enable from the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 sense low group, 1 sense high group, 2 enable mask, 3 flag clear) |
| wr_data_i | input | 8 | Register write data |
| flags_o | output | 8 | Sticky edge flags, one per pin |
| req_o | output | 8 | Per-pin enabled requests |
| irq_o | output | 1 | Combined request qualified by the global enable |
| wake_o | output | 1 | Clock-free wake indication |

## Verification
On every cycle the assertions check that a flag never drops without a clear write, that a clear write always empties the bits it names unless an edge arrives at once, that a level-mode pin never sets its flag, that a rising-mode flag only appears after the synchronized pin went high, and that the wake output only comes from an enabled pin able to wake. The exact three-edge latency from pad change to flag, the bit layout of the two sense bytes, the set-over-clear priority and the immediate, clock-free response of the wake output for each pin and mode can only be shown by the bench's sweep over every pin, every sense value and both edge directions.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int unsigned PIN_COUNT = 8;
    localparam int unsigned SENSE_W   = 2;
    localparam int unsigned ADDR_W    = 2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_SENSE_LO = 2'd0,
        ADDR_SENSE_HI = 2'd1,
        ADDR_ENABLE   = 2'd2,
        ADDR_FLAG_CLR = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int unsigned         WIDTH     = 8,
    parameter int unsigned         STAGES    = 2,
    parameter logic [WIDTH-1:0]    RESET_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            state_d.chain[i] = state_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.chain[STAGES-1];

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter bit ASYNC_EDGE = 1'b1
) (
    input  logic [SENSE_W-1:0] sense_i,
    input  logic               enable_i,
    input  logic               raw_i,
    input  logic               sync_now_i,
    input  logic               sync_prev_i,
    output logic               edge_hit_o,
    output logic               level_hit_o,
    output logic               wake_o
);

    sense_e mode;
    logic   sync_rise, sync_fall;
    logic   pad_rise, pad_fall;
    logic   wake_edge;

    assign mode      = sense_e'(sense_i);
    assign sync_rise = sync_now_i & ~sync_prev_i;
    assign sync_fall = ~sync_now_i & sync_prev_i;
    // pad compared with the last synchronized value: holds while the clock is stopped
    assign pad_rise  = raw_i & ~sync_now_i;
    assign pad_fall  = ~raw_i & sync_now_i;

    always_comb begin
        edge_hit_o = 1'b0;
        unique case (mode)
            SENSE_LOW:  edge_hit_o = 1'b0;
            SENSE_ANY:  edge_hit_o = sync_rise | sync_fall;
            SENSE_FALL: edge_hit_o = sync_fall;
            SENSE_RISE: edge_hit_o = sync_rise;
        endcase
    end

    assign level_hit_o = (mode == SENSE_LOW) & ~sync_now_i;

    if (ASYNC_EDGE) begin : g_async_edge
        always_comb begin
            wake_edge = 1'b0;
            unique case (mode)
                SENSE_LOW:  wake_edge = 1'b0;
                SENSE_ANY:  wake_edge = pad_rise | pad_fall;
                SENSE_FALL: wake_edge = pad_fall;
                SENSE_RISE: wake_edge = pad_rise;
            endcase
        end
    end else begin : g_clocked_edge
        assign wake_edge = 1'b0;
    end

    assign wake_o = enable_i & (((mode == SENSE_LOW) & ~raw_i) | wake_edge);

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = PIN_COUNT,
    localparam int unsigned PER_BYTE = NUM_PINS / SENSE_W
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [NUM_PINS-1:0]               wr_data_i,
    input  logic [NUM_PINS-1:0]               edge_hit_i,
    output logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_o,
    output logic [NUM_PINS-1:0]               enable_o,
    output logic [NUM_PINS-1:0]               flags_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] sense_lo;
        logic [NUM_PINS-1:0] sense_hi;
        logic [NUM_PINS-1:0] enable;
        logic [NUM_PINS-1:0] flags;
    } regs_state_t;

    regs_state_t         state_d, state_q;
    reg_addr_e           addr;
    logic [NUM_PINS-1:0] clr_vec;

    assign addr    = reg_addr_e'(wr_addr_i);
    assign clr_vec = (wr_en_i && addr == ADDR_FLAG_CLR) ? wr_data_i : '0;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            unique case (addr)
                ADDR_SENSE_LO: state_d.sense_lo = wr_data_i;
                ADDR_SENSE_HI: state_d.sense_hi = wr_data_i;
                ADDR_ENABLE:   state_d.enable   = wr_data_i;
                ADDR_FLAG_CLR: ;
            endcase
        end
        // a new edge wins over a clear in the same cycle
        state_d.flags = (state_q.flags & ~clr_vec) | edge_hit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar n = 0; n < int'(NUM_PINS); n++) begin : g_sense_map
        if (n < int'(PER_BYTE)) begin : g_lo
            assign sense_o[n] = state_q.sense_lo[SENSE_W*n +: SENSE_W];
        end else begin : g_hi
            assign sense_o[n] = state_q.sense_hi[SENSE_W*(n-int'(PER_BYTE)) +: SENSE_W];
        end
    end

    assign enable_o = state_q.enable;
    assign flags_o  = state_q.flags;

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~state_q.flags & $past(state_q.flags) & ~$past(clr_vec)) == '0)); // R6

    AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q.flags & $past(clr_vec & ~edge_hit_i)) == '0)); // R6

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS        = PIN_COUNT,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned ASYNC_EDGE_PINS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                gie_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    output logic [NUM_PINS-1:0] flags_o,
    output logic [NUM_PINS-1:0] req_o,
    output logic                irq_o,
    output logic                wake_o
);

    localparam logic [NUM_PINS-1:0] IDLE_LEVEL = '1;
    localparam logic [NUM_PINS-1:0] ASYNC_MASK =
        NUM_PINS'((64'd1 << ASYNC_EDGE_PINS) - 64'd1);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
    } top_state_t;

    top_state_t                       state_d, state_q;
    logic [NUM_PINS-1:0]              sync_now;
    logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
    logic [NUM_PINS-1:0]              enable;
    logic [NUM_PINS-1:0]              flags;
    logic [NUM_PINS-1:0]              edge_hit;
    logic [NUM_PINS-1:0]              level_hit;
    logic [NUM_PINS-1:0]              wake_vec;
    logic [NUM_PINS-1:0]              level_mode;
    logic [NUM_PINS-1:0]              rise_mode;

    ext_irq_sync #(
        .WIDTH     (NUM_PINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IDLE_LEVEL)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins_i),
        .sync_o  (sync_now)
    );

    always_comb begin
        state_d      = state_q;
        state_d.prev = sync_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.prev <= IDLE_LEVEL;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar n = 0; n < int'(NUM_PINS); n++) begin : g_pin
        ext_irq_detect #(
            .ASYNC_EDGE (ASYNC_MASK[n])
        ) detect_i (
            .sense_i     (sense[n]),
            .enable_i    (enable[n]),
            .raw_i       (pins_i[n]),
            .sync_now_i  (sync_now[n]),
            .sync_prev_i (state_q.prev[n]),
            .edge_hit_o  (edge_hit[n]),
            .level_hit_o (level_hit[n]),
            .wake_o      (wake_vec[n])
        );
        assign level_mode[n] = (sense[n] == SENSE_LOW);
        assign rise_mode[n]  = (sense[n] == SENSE_RISE);
    end

    ext_irq_regs #(
        .NUM_PINS (NUM_PINS)
    ) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .edge_hit_i (edge_hit),
        .sense_o    (sense),
        .enable_o   (enable),
        .flags_o    (flags)
    );

    assign flags_o = flags;
    assign req_o   = enable & (flags | level_hit);
    assign irq_o   = gie_i & (|req_o);
    assign wake_o  = |wake_vec;

    AST_LEVEL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flags & ~$past(flags) & $past(level_mode)) == '0)); // R3

    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flags & ~$past(flags) & $past(rise_mode) & ~$past(sync_now)) == '0)); // R4

    AST_WAKE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> ((enable & (level_mode | ASYNC_MASK)) != '0)); // R8

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((req_o & ~regs_i.enable_o) == '0)); // R5

endmodule

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'hFF;
    logic       gie = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] flags, req;
    logic       irq, wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_sense dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pins_i    (pins),
        .gie_i     (gie),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .flags_o   (flags),
        .req_o     (req),
        .irq_o     (irq),
        .wake_o    (wake)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit edge_match(input int m, input bit a, input bit b);
        case (m)
            1: return a != b;
            2: return a & ~b;
            3: return ~a & b;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        #1;
        chk("R1 flags in reset", flags, 8'h00);
        rst_n = 1'b1;
        tick(4);
        #1;
        chk("R1 flags", flags, 8'h00);
        chk("R1 req", req, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 wake", {7'd0, wake}, 8'h00);

        // R3 R4 R5 R7 R8 sweep: every pin, every sense value, both directions
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 2; d++) begin
                    bit st, nw, lvl_pre, lvl_post, hit;
                    logic [7:0] bitp, sv, exp_req;
                    st = (d == 0);
                    nw = ~st;
                    bitp = 8'(1 << p);
                    sv = {4{2'(m)}};
                    wr(2'd2, 8'h00);
                    pins = {8{st}};
                    tick(4);
                    wr(2'd3, 8'hFF);
                    wr(2'd0, sv);
                    wr(2'd1, sv);
                    wr(2'd2, bitp);
                    gie = 1'((p + m + d) % 2);
                    #1;
                    lvl_pre = (m == 0) && !st;
                    chk("R6 flags cleared before toggle", flags, 8'h00);
                    chk("R3 req before toggle", req, lvl_pre ? bitp : 8'h00);
                    chk("R8 wake before toggle", {7'd0, wake}, {7'd0, lvl_pre});
                    pins[p] = nw;
                    #1;
                    lvl_post = (m == 0) && !nw;
                    hit = edge_match(m, st, nw);
                    chk("R8 wake right after pin change", {7'd0, wake},
                        {7'd0, lvl_post | ((p < 4) & hit)});
                    tick(3);
                    #1;
                    chk("R4 flags after three edges", flags, hit ? bitp : 8'h00);
                    exp_req = (hit || lvl_post) ? bitp : 8'h00;
                    chk("R3 R5 req after change", req, exp_req);
                    chk("R7 irq", {7'd0, irq}, {7'd0, gie & (exp_req != 0)});
                    chk("R8 wake settled", {7'd0, wake}, {7'd0, lvl_post});
                end
            end
        end

        // R2: distinct sense bytes; low group rising, high group level
        wr(2'd2, 8'h00);
        pins = 8'hFF;
        tick(4);
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF);
        gie = 1'b1;
        pins = 8'b1101_1101;
        tick(3);
        #1;
        chk("R2 flags with split sense bytes", flags, 8'h00);
        chk("R2 req level on pin 5 only", req, 8'h20);
        // R2: pin 2 field is bits [5:4] of byte 0; make it falling
        wr(2'd0, 8'hEF);
        pins[2] = 1'b0;
        tick(3);
        #1;
        chk("R2 pin 2 falling via bits 5:4", flags, 8'h04);

        // R5: flag sets while disabled, request appears when enabled
        wr(2'd2, 8'h00);
        pins = 8'hFF;
        wr(2'd1, 8'h10);
        tick(4);
        wr(2'd3, 8'hFF);
        #1;
        chk("R6 all flags cleared", flags, 8'h00);
        pins[6] = 1'b0;
        tick(3);
        #1;
        chk("R5 flag set while disabled", flags, 8'h40);
        chk("R5 req masked", req, 8'h00);
        chk("R7 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h40);
        #1;
        chk("R5 req once enabled", req, 8'h40);
        chk("R7 irq once enabled", {7'd0, irq}, 8'h01);
        gie = 1'b0;
        #1;
        chk("R7 irq without global enable", {7'd0, irq}, 8'h00);
        chk("R8 high pin edge gives no wake", {7'd0, wake}, 8'h00);

        // R6: set wins over clear in the same cycle; zero bits do not clear
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h03);
        pins[0] = 1'b0;
        tick(4);
        wr(2'd3, 8'hFF);
        pins[0] = 1'b1;
        tick(2);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
        tick(1);
        wr_en = 1'b0;
        #1;
        chk("R6 set wins over clear", flags, 8'h01);
        wr(2'd3, 8'hFE);
        #1;
        chk("R6 zero bit leaves flag", flags, 8'h01);
        wr(2'd3, 8'h01);
        #1;
        chk("R6 write one clears flag", flags, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule